// File: doc/BRIEF.md
# Framed Serial-to-Parallel Receiver

This block rebuilds an N-bit word sent over a two-wire synchronous link. One wire is a channel-select level and the other carries the data bits. While idle, the receiver watches the select line. When it sees the line high, it takes one data bit on each of the next N clock edges, least significant bit first. The word is framed only by the select level. There is no start bit and no baud timing: transmitter and receiver share one clock.

After the last bit is taken, the receiver raises a ready flag and holds the word. The consumer then takes the word and raises an acknowledge. Until that acknowledge is seen, the receiver ignores all link activity, so a word waiting for its consumer is never overwritten. The acknowledge sends the receiver back to idle, and it can take a new frame on the very next cycle.

Top module: `framed_sp_rx`

## Requirements
- R1: While the active-low asynchronous reset is low, and right after it is released, `wordReady` is 0 and `wordOut` is all zeros.
- R2: In idle, a high `chanSel` sampled at a clock edge starts a frame. The data bit for position i is sampled on the (i+1)-th clock edge after that edge, for i = 0 to N-1.
- R3: Bits arrive least significant first: the k-th data bit of a frame lands in `wordOut[k-1]`. With N = 8, the stream 0,1,1,0,0,0,1,1 assembles to 8'hC6.
- R4: While a frame is being taken, `chanSel` is not looked at. The last bit is captured even though the transmitter drops `chanSel` in that same cycle.
- R5: `wordReady` goes high on the edge that captures bit N-1, and not one cycle earlier.
- R6: While `wordReady` is high and `ack` is low, `wordReady` stays high and `wordOut` does not change, for any number of cycles.
- R7: When `ack` is high at an edge with `wordReady` high, `wordReady` is 0 after that edge and the block is idle. A `chanSel` high on the following edge starts the next frame with no gap.
- R8: `chanSel` and `serData` activity while `wordReady` is high is ignored. No frame starts and the held word is not overwritten.
- R9: In idle with `chanSel` low, `serData` and `ack` have no effect. An `ack` raised in the middle of a frame also has no effect on its reception.
- R10: A reset asserted in the middle of a frame aborts it at once (`wordReady` 0, `wordOut` zeros). The next frame after release is received correctly.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Link and system clock |
| rstN | input | 1 | Asynchronous reset, active low |
| chanSel | input | 1 | Channel-select level from the transmitter |
| serData | input | 1 | Serial data, one bit per clock, LSB first |
| ack | input | 1 | Consumer acknowledge of the held word |
| wordOut | output | N | Assembled parallel word |
| wordReady | output | 1 | High while a complete word waits for acknowledge |

## Verification
The case hardest to reach from the ports is a busy link while a finished word is still waiting for the consumer. In that case `chanSel` and `serData` toggle during the hold, and the acknowledge arrives after a delay of several cycles. The stimulus reaches it by delaying the acknowledge by a chosen number of cycles and driving random link activity during the whole wait. Each frame is also placed right after the acknowledge edge, so the return to idle and the next capture happen with no spare cycle. An acknowledge pulse in the middle of a frame and a reset in the middle of a frame cover the remaining edges of the handshake.

// File: rtl/sp_rx_pkg.sv
`timescale 1ns/1ps
package sp_rx_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RECV = 2'd1,
    ST_HOLD = 2'd2
  } rxState_e;

  // Per-cycle commands from the controller to the datapath.
  typedef struct packed {
    logic clrIdx;
    logic capture;
    logic setReady;
    logic clrReady;
  } rxStrobe_t;

endpackage

// File: rtl/sp_rx_ctrl.sv
`timescale 1ns/1ps
module sp_rx_ctrl
  import sp_rx_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      chanSel,
  input  logic      ack,
  input  logic      idxLast,
  output rxStrobe_t strobe
);

  rxState_e stateQ, stateD;

  always_comb begin
    stateD = stateQ;
    strobe = '0;
    case (stateQ)
      ST_IDLE: begin
        strobe.clrIdx = 1'b1;
        if (chanSel) stateD = ST_RECV;
      end
      ST_RECV: begin
        // chanSel is not looked at here: the frame length alone ends it
        strobe.capture = 1'b1;
        if (idxLast) begin
          strobe.setReady = 1'b1;
          stateD = ST_HOLD;
        end
      end
      ST_HOLD: begin
        if (ack) begin
          strobe.clrReady = 1'b1;
          stateD = ST_IDLE;
        end
      end
      default: stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stateQ <= ST_IDLE;
    else       stateQ <= stateD;
  end

  // R2: select seen in idle opens a frame on the next edge
  p_start_r2: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_IDLE && chanSel) |=> stateQ == ST_RECV);

  // R8: a held word leaves the hold state only through acknowledge
  p_hold_exit_r8: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_HOLD && !ack) |=> stateQ == ST_HOLD);

  p_legal_state_r1: assert property (@(posedge clk) disable iff (!rstN)
    stateQ != 2'd3);

endmodule

// File: rtl/sp_rx_dpath.sv
`timescale 1ns/1ps
module sp_rx_dpath
  import sp_rx_pkg::*;
#(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         serData,
  input  rxStrobe_t    strobe,
  output logic         idxLast,
  output logic [N-1:0] wordOut,
  output logic         wordReady
);

  localparam int IDXW = (N > 1) ? $clog2(N) : 1;
  localparam logic [IDXW-1:0] LASTIDX = IDXW'(N - 1);

  logic [IDXW-1:0] bitIdx;
  logic [N-1:0]    wordQ;
  logic            readyQ;

  assign idxLast = (bitIdx == LASTIDX);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               bitIdx <= '0;
    else if (strobe.clrIdx)  bitIdx <= '0;
    else if (strobe.capture && !idxLast) bitIdx <= bitIdx + 1'b1;
  end

  // One capture flop per bit position, each enabled by its own index match.
  for (genvar g = 0; g < N; g++) begin : g_bit
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        wordQ[g] <= 1'b0;
      else if (strobe.capture && bitIdx == IDXW'(g))
        wordQ[g] <= serData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                readyQ <= 1'b0;
    else if (strobe.setReady) readyQ <= 1'b1;
    else if (strobe.clrReady) readyQ <= 1'b0;
  end

  assign wordOut   = wordQ;
  assign wordReady = readyQ;

  // R3: index walks up one position per captured bit
  p_idx_step_r3: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.capture && !idxLast) |=> bitIdx == IDXW'($past(bitIdx) + 1'b1));

  // R5: ready appears right after the final bit is taken
  p_ready_after_last_r5: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.capture && idxLast) |=> wordReady);

  // R8: no capture happens while a word is held
  p_no_overwrite_r8: assert property (@(posedge clk) disable iff (!rstN)
    wordReady |-> !strobe.capture);

endmodule

// File: rtl/framed_sp_rx.sv
`timescale 1ns/1ps
module framed_sp_rx
  import sp_rx_pkg::*;
#(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         chanSel,
  input  logic         serData,
  input  logic         ack,
  output logic [N-1:0] wordOut,
  output logic         wordReady
);

  rxStrobe_t strobe;
  logic      idxLast;

  sp_rx_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .chanSel (chanSel),
    .ack     (ack),
    .idxLast (idxLast),
    .strobe  (strobe)
  );

  sp_rx_dpath #(.N(N)) u_dpath (
    .clk       (clk),
    .rstN      (rstN),
    .serData   (serData),
    .strobe    (strobe),
    .idxLast   (idxLast),
    .wordOut   (wordOut),
    .wordReady (wordReady)
  );

  // R6: without acknowledge, ready and the word are held
  p_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    (wordReady && !ack) |=> (wordReady && $stable(wordOut)));

  // R7: acknowledge of a held word drops ready on the next edge
  p_ack_drop_r7: assert property (@(posedge clk) disable iff (!rstN)
    (wordReady && ack) |=> !wordReady);

  // R7: the word is not disturbed by its own release
  p_release_stable_r7: assert property (@(posedge clk) disable iff (!rstN)
    (wordReady && ack) |=> $stable(wordOut));

endmodule

// File: tb/framed_sp_rx_tb.sv
`timescale 1ns/1ps
module framed_sp_rx_tb;

  localparam int N = 8;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         chanSel = 1'b0;
  logic         serData = 1'b0;
  logic         ack = 1'b0;
  logic [N-1:0] wordOut;
  logic         wordReady;

  int errs = 0;
  int checks = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  framed_sp_rx #(.N(N)) u_dut (
    .clk       (clk),
    .rstN      (rstN),
    .chanSel   (chanSel),
    .serData   (serData),
    .ack       (ack),
    .wordOut   (wordOut),
    .wordReady (wordReady)
  );

  task automatic check(input string req, input string what,
                       input logic [N-1:0] act, input logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // Start a frame at the current negedge; returns at the negedge after the
  // edge that captured the last bit. ackNoise pulses ack mid-frame (R9).
  task automatic sendFrame(input logic [N-1:0] w, input bit ackNoise);
    chanSel = 1'b1;
    serData = 1'($urandom);
    @(negedge clk);
    for (int i = 0; i < N; i++) begin
      serData = w[i];
      chanSel = (i != N - 1);
      ack     = ackNoise && (i == 2);
      if (i == N - 1) check("R5", "ready before last bit", N'(wordReady), '0);
      @(negedge clk);
    end
    chanSel = 1'b0;
    ack     = 1'b0;
    check("R3", "assembled word", wordOut, w);
    check("R4", "last bit after select drop", N'(wordOut[N-1]), N'(w[N-1]));
    check("R5", "ready after last bit", N'(wordReady), N'(1));
  endtask

  // Hold for a number of cycles (with optional link noise), then acknowledge.
  task automatic ackAfter(input int delay, input bit noise, input logic [N-1:0] w);
    for (int d = 0; d < delay; d++) begin
      if (noise) begin
        chanSel = 1'($urandom);
        serData = 1'($urandom);
      end
      @(negedge clk);
      check("R6", "ready held", N'(wordReady), N'(1));
      check("R8", "word held under link activity", wordOut, w);
    end
    chanSel = 1'b0;
    ack = 1'b1;
    @(negedge clk);
    ack = 1'b0;
    check("R7", "ready dropped by ack", N'(wordReady), '0);
    check("R7", "word kept at release", wordOut, w);
  endtask

  task automatic idleGap(input int n);
    for (int k = 0; k < n; k++) begin
      chanSel = 1'b0;
      serData = 1'($urandom);
      ack     = 1'($urandom);
      @(negedge clk);
      check("R9", "idle stays idle", N'(wordReady), '0);
    end
    ack = 1'b0;
  endtask

  task automatic t_reset();
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    check("R1", "ready in reset", N'(wordReady), '0);
    check("R1", "word in reset", wordOut, '0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1", "ready after release", N'(wordReady), '0);
    check("R1", "word after release", wordOut, '0);
  endtask

  task automatic t_basic();
    sendFrame(8'hC6, 1'b0);
    check("R3", "example stream value", wordOut, 8'hC6);
    ackAfter(1, 1'b0, 8'hC6);
    idleGap(3);
    sendFrame(8'h2D, 1'b0);
    ackAfter(0, 1'b0, 8'h2D);
  endtask

  // R7: next frame starts on the edge right after the ack edge
  task automatic t_backToBack();
    logic [N-1:0] w;
    for (int k = 0; k < 20; k++) begin
      w = N'($urandom);
      sendFrame(w, 1'b0);
      ackAfter(int'($urandom % 6), 1'b0, w);
      if (k % 3 == 1) idleGap(int'($urandom % 5));
    end
  endtask

  task automatic t_holdNoise();
    logic [N-1:0] w;
    for (int k = 0; k < 6; k++) begin
      w = N'($urandom);
      sendFrame(w, 1'b0);
      ackAfter(3 + int'($urandom % 8), 1'b1, w);
    end
  endtask

  task automatic t_idleNoise();
    idleGap(12);
    sendFrame(8'hA5, 1'b1);
    check("R9", "mid-frame ack ignored", wordOut, 8'hA5);
    ackAfter(2, 1'b0, 8'hA5);
  endtask

  task automatic t_resetMidFrame();
    chanSel = 1'b1;
    @(negedge clk);
    for (int i = 0; i < 4; i++) begin
      serData = 1'b1;
      @(negedge clk);
    end
    rstN = 1'b0;
    #1;
    check("R10", "ready at abort", N'(wordReady), '0);
    check("R10", "word at abort", wordOut, '0);
    chanSel = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R10", "no stray ready", N'(wordReady), '0);
    sendFrame(8'h3C, 1'b0);
    check("R10", "frame after abort", wordOut, 8'h3C);
    ackAfter(1, 1'b0, 8'h3C);
  endtask

  initial begin
    t_reset();
    t_basic();
    t_backToBack();
    t_holdNoise();
    t_idleNoise();
    t_resetMidFrame();
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      errs++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

endmodule